// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Gate Controller

This block controls a clock fan-out stage. One reference clock is spread onto twelve output pairs, each with a true and a complement leg, plus one feedback output. A write-only SMBus target holds one enable bit per pair and one for the feedback output. A host writes these bits with ordinary SMBus block writes. A disabled pair holds both of its legs low.

Two pins act above the register state. A mode select decides how the complement legs of the lower six pairs behave. With the select high they are inverted clocks. With the select low they are in-phase copies, so they can drive single-ended loads. The complement legs of the upper six pairs are always inverted. An active-low power-down pin forces every output low at once.

The bus is sampled in a system clock domain. The enable bits cross into the reference clock domain through a synchronizer. They reach each output leg only while that leg is low, so a change never cuts a pulse short.

Top module: `ckfan_top`

## Requirements
- R1: The target acknowledges only the address byte 1101001 followed by a write bit of 0, i.e. the byte 0xD2. Any other address byte, including 0xD3, gets no acknowledge, and the data bytes that follow it do not change any enable.
- R2: Data bytes are received most significant bit first. The first data byte after the address is byte index 0, and the index rises by one per byte. Bytes with index 0 to 5, and any byte after index 7, are acknowledged and change nothing.
- R3: In byte 7, bit k (k = 0..7) enables pair k. A 1 enables the pair and a 0 disables it.
- R4: In byte 6, bits 3..0 enable pairs 11..8 and bit 4 enables the feedback output. Bits 7..5 have no effect.
- R5: After reset every enable bit is 1, so all pairs and the feedback output run.
- R6: While the power-down input is 0, every true, complement and feedback output is 0 whatever the enables are.
- R7: For pairs 0..5, the complement leg is the inverted reference when the mode select is 1 and the non-inverted reference when it is 0.
- R8: The complement legs of pairs 6..11 are always the inverted reference. Every true leg and the feedback output are the non-inverted reference.
- R9: A disabled pair holds both legs at 0, and a disabled feedback output is 0.
- R10: A stop condition or a repeated start sets the byte index back to 0.
- R11: For every acknowledged byte the target pulls SDA low during the ninth SCL high phase.
- R12: A new enable value reaches the outputs within four reference cycles after the byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock that samples the serial bus |
| rst | input | 1 | Synchronous active-high reset, used in both clock domains |
| scl_in | input | 1 | Serial bus clock |
| sda_in | input | 1 | Serial bus data as seen on the wire |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| ref_clk | input | 1 | Reference clock to distribute |
| mode_sel | input | 1 | 1 = lower complement legs inverted, 0 = in phase |
| pwr_dn_n | input | 1 | Active-low power-down, forces all outputs low |
| out_t | output | 12 | True legs of pairs 11..0 |
| out_c | output | 12 | Complement legs of pairs 11..0 |
| fb_out | output | 1 | Feedback clock output |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except at start and stop conditions. Each SCL phase lasts many system clocks, so the synchronized edge events are distinct and in order. The reference clock runs while reset is held, so the reference-domain registers see the reset. The bench's bus tasks change SDA a few system cycles after SCL falls and keep both SCL phases ten system cycles long. Random mixes of address bytes, transfer lengths, repeated starts, mode and power-down levels all go through those same tasks, so the stimulus stays inside these assumptions.

// File: rtl/ckfan_pkg.sv
package ckfan_pkg;
    localparam int        N_PAIRS   = 12;
    localparam int        HALF      = 6;
    localparam int        N_EN      = N_PAIRS + 1;
    localparam int        FB_BIT    = N_PAIRS;
    localparam int        IDX_W     = 4;
    localparam logic [6:0] DEV_ADDR = 7'b1101001;
    localparam int        BYTE_LO   = 7;
    localparam int        BYTE_HI   = 6;
    localparam int        HI_PAIRS  = N_PAIRS - 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK_A, ST_DATA, ST_ACK_D
    } smb_st_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } byte_wr_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic comp_is_inverted(input int pair, input logic mode);
        return (pair >= HALF) || mode;
    endfunction
endpackage

// File: rtl/ckfan_bus_sync.sv
module ckfan_bus_sync
    import ckfan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[TOP-1:0], scl_in};
            sda_p <= {sda_p[TOP-1:0], sda_in};
            scl_q <= scl_p[TOP];
            sda_q <= sda_p[TOP];
        end
    end

    always_comb begin
        ev.rise  = scl_p[TOP] & ~scl_q;
        ev.fall  = ~scl_p[TOP] & scl_q;
        ev.start = scl_q & scl_p[TOP] & sda_q & ~sda_p[TOP];
        ev.stop  = scl_q & scl_p[TOP] & ~sda_q & sda_p[TOP];
        ev.sda   = sda_p[TOP];
    end
endmodule

// File: rtl/ckfan_smb_target.sv
module ckfan_smb_target
    import ckfan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_ev_t  ev,
    output byte_wr_t wr,
    output logic     ack_pull
);
    smb_st_e          st;
    logic [3:0]       bitcnt;
    logic [7:0]       sh;
    logic [IDX_W-1:0] byte_idx;
    logic             ack_q;
    byte_wr_t         wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            sh       <= '0;
            byte_idx <= '0;
            ack_q    <= 1'b0;
            wr_q     <= '0;
        end else begin
            wr_q.valid <= 1'b0;
            if (ev.start) begin
                st       <= ST_ADDR;
                bitcnt   <= '0;
                byte_idx <= '0;
                ack_q    <= 1'b0;
            end else if (ev.stop) begin
                st       <= ST_IDLE;
                byte_idx <= '0;
                ack_q    <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_DATA: begin
                        if (ev.rise && bitcnt < 4'd8) begin
                            sh     <= {sh[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (st == ST_ADDR) begin
                                if (sh == {DEV_ADDR, 1'b0}) begin
                                    st    <= ST_ACK_A;
                                    ack_q <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                st    <= ST_ACK_D;
                                ack_q <= 1'b1;
                                wr_q  <= '{valid: 1'b1, idx: byte_idx, data: sh};
                            end
                        end
                    end
                    ST_ACK_A, ST_ACK_D: begin
                        if (ev.fall) begin
                            ack_q <= 1'b0;
                            st    <= ST_DATA;
                            if (st == ST_ACK_D && byte_idx != '1)
                                byte_idx <= byte_idx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr       = wr_q;
    assign ack_pull = ack_q;

    // R11: acknowledge is raised only just after an SCL falling edge
    a_r11_ack_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(ev.fall));

    // R1: an address acknowledge requires the matching address with write bit
    a_r1_addr_match: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_q) && $past(st) == ST_ADDR) |-> ($past(sh) == {DEV_ADDR, 1'b0}));

    // R10: a start (also a repeated one) restarts the byte index
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (byte_idx == '0 && st == ST_ADDR));
endmodule

// File: rtl/ckfan_en_regs.sv
module ckfan_en_regs
    import ckfan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  byte_wr_t        wr,
    output logic [N_EN-1:0] en
);
    logic [N_EN-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '1;
        end else if (wr.valid) begin
            if (wr.idx == IDX_W'(BYTE_LO)) begin
                en_q[7:0] <= wr.data;
            end else if (wr.idx == IDX_W'(BYTE_HI)) begin
                en_q[N_PAIRS-1:8] <= wr.data[HI_PAIRS-1:0];
                en_q[FB_BIT]      <= wr.data[HI_PAIRS];
            end
        end
    end

    assign en = en_q;

    // R5: first cycle out of reset shows every enable set
    a_r5_reset_all_on: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '1));

    // R2: bytes other than the two enable bytes leave the enables alone
    a_r2_other_bytes_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.idx != IDX_W'(BYTE_LO) && wr.idx != IDX_W'(BYTE_HI)) |=> $stable(en_q));

    // R4: reserved upper bits of the high byte do not leak into the enables
    a_r4_reserved_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.idx == IDX_W'(BYTE_HI) && (|wr.data[7:HI_PAIRS+1]))
        |=> (en_q[FB_BIT:8] == $past(wr.data[HI_PAIRS:0])));
endmodule

// File: rtl/ckfan_gate_bank.sv
module ckfan_gate_bank
    import ckfan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic               ref_clk,
    input  logic               rst,
    input  logic [N_EN-1:0]    en_sys,
    input  logic               mode_sel,
    input  logic               pwr_dn_n,
    output logic [N_PAIRS-1:0] out_t,
    output logic [N_PAIRS-1:0] out_c,
    output logic               fb_out
);
    logic [N_EN-1:0] chain [STAGES];
    logic [N_EN-1:0] en_t;
    logic [N_EN-1:0] en_c;

    always_ff @(posedge ref_clk) begin
        if (rst) chain[0] <= '1;
        else     chain[0] <= en_sys;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_sync
        always_ff @(posedge ref_clk) begin
            if (rst) chain[s] <= '1;
            else     chain[s] <= chain[s-1];
        end
    end

    // inverted legs are low after the rising edge: update there
    always_ff @(posedge ref_clk) begin
        if (rst) en_c <= '1;
        else     en_c <= chain[STAGES-1];
    end

    // in-phase legs are low after the falling edge: update there
    always_ff @(negedge ref_clk) begin
        if (rst) en_t <= '1;
        else     en_t <= chain[STAGES-1];
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        assign out_t[p] = pwr_dn_n & en_t[p] & ref_clk;
        if (p >= HALF) begin : g_inv
            assign out_c[p] = pwr_dn_n & en_c[p] & ~ref_clk;
        end else begin : g_sel
            assign out_c[p] = pwr_dn_n & (comp_is_inverted(p, mode_sel)
                                          ? (en_c[p] & ~ref_clk)
                                          : (en_t[p] & ref_clk));
        end
    end

    assign fb_out = pwr_dn_n & en_t[FB_BIT] & ref_clk;
endmodule

// File: rtl/ckfan_top.sv
module ckfan_top
    import ckfan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_sys,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               ref_clk,
    input  logic               mode_sel,
    input  logic               pwr_dn_n,
    output logic [N_PAIRS-1:0] out_t,
    output logic [N_PAIRS-1:0] out_c,
    output logic               fb_out
);
    bus_ev_t         ev;
    byte_wr_t        wr;
    logic [N_EN-1:0] en;

    ckfan_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_sys), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    ckfan_smb_target u_tgt (
        .clk(clk_sys), .rst(rst), .ev(ev), .wr(wr), .ack_pull(sda_pull)
    );

    ckfan_en_regs u_regs (
        .clk(clk_sys), .rst(rst), .wr(wr), .en(en)
    );

    ckfan_gate_bank #(.STAGES(SYNC_STAGES)) u_gate (
        .ref_clk(ref_clk), .rst(rst), .en_sys(en), .mode_sel(mode_sel),
        .pwr_dn_n(pwr_dn_n), .out_t(out_t), .out_c(out_c), .fb_out(fb_out)
    );

    // R6: power-down wins over every enable and over the mode select
    a_r6_pd_forces_low: assert property (@(posedge clk_sys) disable iff (rst)
        !pwr_dn_n |-> (out_t == '0 && out_c == '0 && !fb_out));
endmodule

// File: tb/sim_ckfan_top.sv
module sim_ckfan_top;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        mode = 1'b1;
    logic        pdn = 1'b1;
    logic        sda_pull;
    logic [11:0] out_t, out_c;
    logic        fb_out;
    wire         sda_bus = sda_m & ~sda_pull;

    int          checks = 0;
    int          failures = 0;
    logic [12:0] en_exp = '1;
    logic [7:0]  tx [16];
    bit          bus_held = 1'b0;

    always #2.5 clk = ~clk;
    always #17 ref_clk = ~ref_clk;

    ckfan_top u0 (
        .clk_sys(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .ref_clk(ref_clk), .mode_sel(mode),
        .pwr_dn_n(pdn), .out_t(out_t), .out_c(out_c), .fb_out(fb_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [24:0] expect_phase(input bit high);
        logic [11:0] t, c;
        logic        f;
        for (int i = 0; i < 12; i++) begin
            bit inv = (i >= 6) || mode;
            t[i] = pdn & en_exp[i] & high;
            c[i] = pdn & en_exp[i] & (inv ? !high : high);
        end
        f = pdn & en_exp[12] & high;
        return {f, c, t};
    endfunction

    task automatic check_outputs(input string req);
        repeat (4) @(posedge ref_clk);
        #4;
        check({fb_out, out_c, out_t} == expect_phase(1'b1), req,
              32'({fb_out, out_c, out_t}), 32'(expect_phase(1'b1)));
        @(negedge ref_clk);
        #4;
        check({fb_out, out_c, out_t} == expect_phase(1'b0), req,
              32'({fb_out, out_c, out_t}), 32'(expect_phase(1'b0)));
    endtask

    task automatic bus_start();
        if (bus_held) begin
            sda_m = 1'b1; wait_sys(Q);
            scl = 1'b1;   wait_sys(Q);
        end else begin
            sda_m = 1'b1; scl = 1'b1; wait_sys(Q);
        end
        sda_m = 1'b0; wait_sys(Q);
        scl = 1'b0;   wait_sys(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_sys(Q);
        scl = 1'b1;   wait_sys(Q);
        sda_m = 1'b1; wait_sys(Q);
        bus_held = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_sys(Q);
            scl = 1'b1;   wait_sys(Q);
            scl = 1'b0;   wait_sys(2);
        end
        sda_m = 1'b1; wait_sys(Q);
        scl = 1'b1;   wait_sys(Q / 2);
        acked = sda_pull;
        wait_sys(Q / 2);
        scl = 1'b0;   wait_sys(2);
    endtask

    task automatic xfer(input logic [7:0] abyte, input int n, input bit hold);
        bit ack;
        bit hit = (abyte == 8'hD2);
        bus_start();
        send_byte(abyte, ack);
        check(ack == hit, "R1 R11 address acknowledge", 32'(ack), 32'(hit));
        for (int k = 0; k < n; k++) begin
            send_byte(tx[k], ack);
            check(ack == hit, "R1 R2 R11 data acknowledge", 32'(ack), 32'(hit));
            if (hit && k == 7) en_exp[7:0] = tx[k];
            if (hit && k == 6) en_exp[12:8] = tx[k][4:0];
        end
        if (hold) bus_held = 1'b1;
        else      bus_stop();
    endtask

    initial begin
        #950000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) tx[i] = 8'h00;
        wait_sys(20);
        rst = 1'b0;
        wait_sys(4);

        check(sda_pull == 1'b0, "R5 no acknowledge after reset", 32'(sda_pull), 0);
        check_outputs("R5 R8 all enabled after reset");

        tx[6] = 8'hE5;
        tx[7] = 8'hA5;
        xfer(8'hD2, 8, 1'b0);
        check_outputs("R3 R4 R9 R12 enable bytes applied");

        tx[6] = 8'h1F;
        tx[7] = 8'hFF;
        xfer(8'hD0, 8, 1'b0);
        check_outputs("R1 wrong address ignored");
        xfer(8'hD3, 8, 1'b0);
        check_outputs("R1 read bit ignored");

        for (int i = 0; i < 6; i++) tx[i] = 8'h3C;
        tx[6] = 8'h0A;
        tx[7] = 8'h5A;
        tx[8] = 8'h00;
        tx[9] = 8'h00;
        xfer(8'hD2, 10, 1'b0);
        check_outputs("R2 bytes 0-5 and beyond 7 ignored");

        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
        xfer(8'hD2, 3, 1'b1);
        tx[0] = 8'h00; tx[1] = 8'h00; tx[2] = 8'h00;
        tx[3] = 8'h77; tx[4] = 8'h66; tx[5] = 8'h55;
        tx[6] = 8'h13;
        tx[7] = 8'hC3;
        xfer(8'hD2, 8, 1'b0);
        check_outputs("R10 repeated start restarts index");

        tx[6] = 8'h00; tx[7] = 8'h00;
        xfer(8'hD2, 7, 1'b0);
        xfer(8'hD2, 8, 1'b0);
        check_outputs("R10 stop restarts index");

        tx[6] = 8'h1F; tx[7] = 8'hFF;
        xfer(8'hD2, 8, 1'b0);
        mode = 1'b0;
        check_outputs("R7 in-phase lower complements");
        mode = 1'b1;
        check_outputs("R7 R8 inverted complements");

        pdn = 1'b0;
        check_outputs("R6 power-down forces low");
        mode = 1'b0;
        check_outputs("R6 power-down with mode low");
        pdn = 1'b1;
        check_outputs("R6 R12 outputs return after power-down");

        for (int r = 0; r < 24; r++) begin
            int n = 1 + int'($urandom_range(9));
            logic [7:0] ab = ($urandom_range(3) != 0) ? 8'hD2 : 8'($urandom);
            bit hold = ($urandom_range(4) == 0);
            for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
            mode = 1'($urandom);
            pdn = ($urandom_range(6) != 0);
            xfer(ab, n, hold);
            check_outputs("R3 R4 R7 R8 R9 R12 random traffic");
        end
        if (bus_held) bus_stop();
        check_outputs("R12 final state");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule